// File: doc/BRIEF.md
# Page-mode ROM read datapath

A cycle-based model of the read side of a page-mode read-only memory whose data width is selectable. With the width select high, each address names a 32-bit double word. With it low, each address names a pair of 16-bit words. An extra low address bit then picks one of the two halves, and only the lower 16 data lanes are driven. In the physical part that extra bit shares a pin with the top data bit.

Array contents are not stored. Each double word is computed from its address by a fixed hash, so any depth can be modelled without memory.

A read whose upper address bits, width and enable state match the page that is currently latched finishes after a short latency. Any other read pays the full random-access latency. A valid flag rises when the read completes. It falls in the same cycle that the address, the width select, chip enable or (in 16-bit mode) the extra low bit changes.

Top module: `rom_page_reader`

## Requirements
- R1: With `wide_i` high and `valid_o` high, `data_o` equals H(addr_i), where H(a) is computed on a 32-bit value: h = a*0x9E3779B1; h ^= h>>16; h = h*0x85EBCA6B; h ^= h>>13 (all arithmetic mod 2^32).
- R2: With `wide_i` low and `valid_o` high, `data_o[15:0]` is H(addr_i)[15:0] when `lo_addr_i` is 0 and H(addr_i)[31:16] when it is 1, and `data_o[31:16]` is 0.
- R3: With `wide_i` low, `data_oe_o[31:16]` is 0. With chip and output enable both low, `data_oe_o[15:0]` is all ones.
- R4: When `ce_ni` or `oe_ni` is high, `data_oe_o` is 0. When `ce_ni` is high, `valid_o` is 0.
- R5: A read that is not a page hit raises `valid_o` after the RAND_LAT-th rising edge that samples its inputs (default 8).
- R6: A read is a page hit when a page is open, `ce_ni` has stayed low since that page opened, `addr_i[ADDR_W-1:3]` and `wide_i` match the open page, and the read differs from the previous one only below that field. A page hit raises `valid_o` after PAGE_LAT edges (default 3). A page opens when a read completes, and an aborted read leaves the previous page open.
- R7: `valid_o` goes low in the same cycle that `addr_i`, `wide_i` or `ce_ni` changes, or `lo_addr_i` changes while `wide_i` is low.
- R8: With `wide_i` high, changes on `lo_addr_i` have no effect on `valid_o` or `data_o`.
- R9: Raising `ce_ni` closes the open page, so the next read is a miss even if it uses the same address.
- R10: A change of `wide_i` makes the next read a miss.
- R11: After reset with `ce_ni` high, `valid_o` and `data_oe_o` are 0.
- R12: Toggling `oe_ni` does not restart a read. Once `oe_ni` returns low, the completed data is driven at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Double-word address |
| lo_addr_i | input | 1 | Half-select address bit, used only in 16-bit mode |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| wide_i | input | 1 | 1: 32-bit organisation, 0: 16-bit organisation |
| data_o | output | 32 | Read data, zero where not driven |
| data_oe_o | output | 32 | Per-bit output enable |
| valid_o | output | 1 | Read data is complete for the present inputs |

## Verification
The bench applies, for each organisation, three kinds of access:
- a first access to a page, which must take the long latency;
- an access elsewhere in the same page, which must take the short latency;
- a change of page, width or chip enable, which must fall back to the long latency.

Together these separate the hit rule from the miss rule. Half-select toggles are applied in both modes, which shows that the bit is decoded in 16-bit mode and ignored in 32-bit mode. An aborted miss followed by a return to the old page checks that an unfinished read does not replace the latched page. A long pseudo-random stretch mixes addresses, widths, enable pulses and hold times, and compares every cycle against a behavioural model.

// File: rtl/rom_rd_pkg.sv
package rom_rd_pkg;
  localparam int DATA_W = 32;
  localparam int HALF_W = 16;

  function automatic logic [DATA_W-1:0] rom_hash(input logic [31:0] a);
    logic [31:0] h;
    h = a * 32'h9E37_79B1;
    h = h ^ (h >> 16);
    h = h * 32'h85EB_CA6B;
    h = h ^ (h >> 13);
    return h;
  endfunction
endpackage

// File: rtl/rom_pattern_gen.sv
module rom_pattern_gen
  import rom_rd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] word_o
);
  assign word_o = rom_hash(32'(addr_i));
endmodule

// File: rtl/rom_page_ctl.sv
module rom_page_ctl #(
  parameter int ADDR_W   = 20,
  parameter int PAGE_W   = 3,
  parameter int RAND_LAT = 8,
  parameter int PAGE_LAT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              lo_i,
  input  logic              wide_i,
  input  logic              ce_ni,
  output logic              valid_o
);
  localparam int CNT_W = $clog2(RAND_LAT + 1);
  localparam int TAG_W = ADDR_W - PAGE_W;
  localparam logic [CNT_W-1:0] LAT_RAND = CNT_W'(RAND_LAT);
  localparam logic [CNT_W-1:0] LAT_PAGE = CNT_W'(PAGE_LAT);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [ADDR_W-1:0] addr_q;
  logic              lo_q, wide_q, ce_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              valid_q;
  logic              open_q, tag_wide_q;
  logic [TAG_W-1:0]  tag_q;

  logic             eff_lo, chg, hit, fin;
  logic [CNT_W-1:0] lat;

  // half-select only counts in 16-bit mode
  assign eff_lo = wide_i ? 1'b0 : lo_i;
  assign chg    = (addr_i != addr_q) | (wide_i != wide_q) | (eff_lo != lo_q) | ce_q;
  assign hit    = open_q & (addr_i[ADDR_W-1:PAGE_W] == tag_q) & (wide_i == tag_wide_q);
  assign lat    = hit ? LAT_PAGE : LAT_RAND;
  assign fin    = ~ce_ni & (chg ? (lat == ONE) : (cnt_q == ONE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q     <= '0;
      lo_q       <= 1'b0;
      wide_q     <= 1'b1;
      ce_q       <= 1'b1;
      cnt_q      <= '0;
      valid_q    <= 1'b0;
      open_q     <= 1'b0;
      tag_wide_q <= 1'b0;
      tag_q      <= '0;
    end else begin
      addr_q <= addr_i;
      lo_q   <= eff_lo;
      wide_q <= wide_i;
      ce_q   <= ce_ni;
      if (ce_ni) begin
        cnt_q   <= '0;
        valid_q <= 1'b0;
        open_q  <= 1'b0;
      end else if (chg) begin
        cnt_q   <= lat - ONE;
        valid_q <= (lat == ONE);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - ONE;
        if (cnt_q == ONE) valid_q <= 1'b1;
      end
      if (fin) begin
        open_q     <= 1'b1;
        tag_q      <= addr_i[ADDR_W-1:PAGE_W];
        tag_wide_q <= wide_i;
      end
    end
  end

  assign valid_o = valid_q & ~chg & ~ce_ni;

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(RAND_LAT - 1));
  p_valid_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !chg && !ce_ni) |=> valid_q);
  p_hit_short_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && chg && hit) |=> (cnt_q == CNT_W'(PAGE_LAT - 1)));
  p_close_page_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |=> !open_q);
endmodule

// File: rtl/rom_out_stage.sv
module rom_out_stage
  import rom_rd_pkg::*;
(
  input  logic [DATA_W-1:0] word_i,
  input  logic              wide_i,
  input  logic              lo_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              valid_i,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] data_oe_o
);
  localparam int LANES = DATA_W / HALF_W;

  logic drive;
  assign drive = ~ce_ni & ~oe_ni;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic             en;
    logic [HALF_W-1:0] val;
    if (g == 0) begin : g_low
      assign en  = drive;
      assign val = (!wide_i && lo_i) ? word_i[DATA_W-1:HALF_W] : word_i[HALF_W-1:0];
    end else begin : g_high
      assign en  = drive & wide_i;
      assign val = word_i[g*HALF_W +: HALF_W];
    end
    assign data_oe_o[g*HALF_W +: HALF_W] = {HALF_W{en}};
    assign data_o[g*HALF_W +: HALF_W]    = (en & valid_i) ? val : '0;
  end
endmodule

// File: rtl/rom_page_reader.sv
module rom_page_reader
  import rom_rd_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int PAGE_W   = 3,
  parameter int RAND_LAT = 8,
  parameter int PAGE_LAT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              lo_addr_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              wide_i,
  output logic [31:0]       data_o,
  output logic [31:0]       data_oe_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] word;
  logic              vld;

  rom_pattern_gen #(.ADDR_W(ADDR_W)) u_pat (
    .addr_i (addr_i),
    .word_o (word)
  );

  rom_page_ctl #(
    .ADDR_W   (ADDR_W),
    .PAGE_W   (PAGE_W),
    .RAND_LAT (RAND_LAT),
    .PAGE_LAT (PAGE_LAT)
  ) u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .lo_i    (lo_addr_i),
    .wide_i  (wide_i),
    .ce_ni   (ce_ni),
    .valid_o (vld)
  );

  rom_out_stage u_out (
    .word_i    (word),
    .wide_i    (wide_i),
    .lo_i      (lo_addr_i),
    .ce_ni     (ce_ni),
    .oe_ni     (oe_ni),
    .valid_i   (vld),
    .data_o    (data_o),
    .data_oe_o (data_oe_o)
  );

  assign valid_o = vld;

  p_idle_hiz_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni || oe_ni) |-> (data_oe_o == '0));
  p_narrow_hiz_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wide_i |-> (data_oe_o[31:16] == '0));
  p_standby_novalid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> !valid_o);
endmodule

// File: tb/rom_page_reader_tb_top.sv
`timescale 1ns/1ps
module rom_page_reader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int RL = 8;
  localparam int PL = 3;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          lo = 1'b0, ce_n = 1'b1, oe_n = 1'b0, wide = 1'b1;
  logic [31:0]   data_o, data_oe_o;
  logic          valid_o;

  int  n_vec = 0, n_fail = 0;
  bit  run_chk = 1'b0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rom_page_reader #(.ADDR_W(AW), .PAGE_W(3), .RAND_LAT(RL), .PAGE_LAT(PL)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .lo_addr_i(lo), .ce_ni(ce_n),
    .oe_ni(oe_n), .wide_i(wide), .data_o(data_o), .data_oe_o(data_oe_o), .valid_o(valid_o)
  );

  function automatic bit [31:0] hsh(input bit [31:0] a);
    bit [31:0] h;
    h = a * 32'h9E3779B1;
    h = h ^ (h >> 16);
    h = h * 32'h85EBCA6B;
    h = h ^ (h >> 13);
    return h;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference: remaining edges, open page tag
  int  m_left;
  bit  m_valid, m_open, m_twide;
  int  m_tag;
  int  s_addr;
  bit  s_lo, s_wide, s_ce;

  function automatic bit in_changed();
    bit el = wide ? 1'b0 : lo;
    return (int'(addr) != s_addr) || (wide != s_wide) || (el != s_lo) || s_ce;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_left = 0; m_valid = 0; m_open = 0; m_twide = 0; m_tag = 0;
      s_addr = 0; s_lo = 0; s_wide = 1; s_ce = 1;
    end else begin
      if (ce_n) begin
        m_open = 0; m_valid = 0; m_left = 0;
      end else begin
        if (in_changed()) begin
          m_left  = (m_open && m_tag == (int'(addr) >> 3) && m_twide == wide) ? PL : RL;
          m_valid = 0;
        end
        if (!m_valid && m_left > 0) begin
          m_left--;
          if (m_left == 0) begin
            m_valid = 1; m_open = 1; m_tag = int'(addr) >> 3; m_twide = wide;
          end
        end
      end
      s_addr = int'(addr); s_lo = wide ? 1'b0 : lo; s_wide = wide; s_ce = ce_n;
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_ni && run_chk) begin
      bit          ev;
      bit [31:0]   eoe, ed, h;
      ev  = m_valid && !in_changed() && !ce_n;
      eoe = (ce_n || oe_n) ? 32'h0 : (wide ? 32'hFFFF_FFFF : 32'h0000_FFFF);
      h   = hsh(32'(addr));
      ed  = wide ? h : {16'h0, (lo ? h[31:16] : h[15:0])};
      chk(valid_o === ev, in_changed() ? "R7" : "R5", "valid", 32'(valid_o), 32'(ev));
      chk(data_oe_o === eoe, wide ? "R4" : "R3", "oe", data_oe_o, eoe);
      if (ev && !oe_n) chk(data_o === ed, wide ? "R1" : "R2", "data", data_o, ed);
    end
  end

  task automatic put(input int a, input bit l, input bit w, input bit c, input bit o);
    @(negedge clk);
    addr = AW'(a); lo = l; wide = w; ce_n = c; oe_n = o;
  endtask

  task automatic meas(input int exp_l, input string tag);
    int n = 0;
    bit got = 0;
    while (!got && n < 40) begin
      @(posedge clk); n++;
      @(negedge clk); #3;
      got = valid_o;
    end
    chk(n == exp_l, tag, "latency", 32'(n), 32'(exp_l));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned r = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #3;
    // R11 reset state
    chk(valid_o === 1'b0, "R11", "valid after reset", 32'(valid_o), 0);
    chk(data_oe_o === 32'h0, "R11", "oe after reset", data_oe_o, 0);
    run_chk = 1'b1;

    put('h12340, 0, 1, 0, 0); meas(RL, "R5");
    chk(data_o === hsh('h12340), "R1", "wide data", data_o, hsh('h12340));
    put('h12345, 0, 1, 0, 0); meas(PL, "R6");

    // R8 half-select ignored in 32-bit mode
    put('h12345, 1, 1, 0, 0); #3;
    chk(valid_o === 1'b1, "R8", "valid on lo toggle", 32'(valid_o), 1);
    chk(data_o === hsh('h12345), "R8", "data on lo toggle", data_o, hsh('h12345));

    // R12 output enable toggles
    put('h12345, 1, 1, 0, 1); #3;
    chk(data_oe_o === 32'h0, "R4", "oe high", data_oe_o, 0);
    put('h12345, 1, 1, 0, 0); #3;
    chk(valid_o === 1'b1, "R12", "valid after oe", 32'(valid_o), 1);
    chk(data_o === hsh('h12345), "R12", "data after oe", data_o, hsh('h12345));

    // R7 immediate drop
    put('h12346, 1, 1, 0, 0); #1;
    chk(valid_o === 1'b0, "R7", "drop on addr change", 32'(valid_o), 0);
    meas(PL, "R6");

    // aborted miss keeps old page
    put('h50000, 0, 1, 0, 0);
    repeat (3) @(negedge clk);
    put('h12341, 0, 1, 0, 0); meas(PL, "R6");

    // R10 width switch
    put('h12341, 0, 0, 0, 0); meas(RL, "R10");
    chk(data_o === {16'h0, hsh('h12341) & 32'hFFFF}, "R2", "low half", data_o, {16'h0, hsh('h12341) & 32'hFFFF});
    chk(data_oe_o === 32'h0000_FFFF, "R3", "narrow oe", data_oe_o, 32'h0000_FFFF);
    put('h12341, 1, 0, 0, 0); #1;
    chk(valid_o === 1'b0, "R7", "drop on lo change", 32'(valid_o), 0);
    meas(PL, "R6");
    chk(data_o === {16'h0, hsh('h12341) >> 16}, "R2", "high half", data_o, {16'h0, hsh('h12341) >> 16});
    put('h12347, 1, 0, 0, 0); meas(PL, "R6");

    // R9 standby closes the page
    put('h12347, 1, 0, 1, 0); #3;
    chk(valid_o === 1'b0, "R4", "standby valid", 32'(valid_o), 0);
    chk(data_oe_o === 32'h0, "R4", "standby oe", data_oe_o, 0);
    put('h12347, 1, 0, 0, 0); meas(RL, "R9");

    // mixed pseudo-random traffic, per-cycle compare
    for (int i = 0; i < 400; i++) begin
      int base, hold;
      r = r * 32'd1664525 + 32'd1013904223;
      base = ((r >> 20) % 3) * 'h8 + 'h2A000;
      hold = int'((r >> 8) % 12);
      put(base + int'((r >> 4) & 7), r[28], (r[30:29] != 2'b00), (r[27:24] == 4'h0), (r[23:21] == 3'h0));
      repeat (hold) @(negedge clk);
    end
    repeat (12) @(negedge clk);
    run_chk = 1'b0;
    finish_run();
  end
endmodule